// File: doc/BRIEF.md
# ADC Sample Formatter with DC Removal

This block takes one 14-bit converter sample per valid cycle and turns it into a 16-bit signed word. Three control bits decide how the raw code is read: with formatting off the code is zero-padded to 16 bits. With formatting on, the code is read either as offset binary, which becomes two's complement when its top bit is inverted, or as two's complement, which can be sign-extended to the 16-bit byte boundary or left zero-padded. A signed 16-bit offset is added next, with saturation, to cancel a known DC level.

An optional first-order high-pass stage then removes any remaining DC. It keeps a running estimate of the DC level in an accumulator and subtracts that estimate from each sample. The estimate moves toward the input by a fraction that is set by a signed coefficient with 14 fraction bits. The result is saturated to 16 bits and leaves the block exactly two clock cycles after the sample entered.

Top module: `adc_sample_conditioner`

## Requirements
- R1: With `fmt_en` low, the converted value is the raw code zero-padded to 16 bits, whatever `fmt_offbin` and `fmt_sext` hold.
- R2: With `fmt_en` high and `fmt_offbin` high, bit 13 of the code is inverted and the 14-bit result is sign-extended to 16 bits (code 0x0000 gives -8192, 0x2000 gives 0, 0x3FFF gives 8191); `fmt_sext` has no effect in this mode.
- R3: With `fmt_en` high, `fmt_offbin` low and `fmt_sext` high, bits 15:14 copy bit 13 of the code (0x3FFF gives -1, 0x2000 gives -8192).
- R4: With `fmt_en` high, `fmt_offbin` low and `fmt_sext` low, the code is zero-padded (0x3FFF gives 16383).
- R5: The signed `dc_offset` is added to the converted value, and the sum saturates to the range -32768..32767.
- R6: With `dc_en` low, the output equals the offset-corrected value, and the filter accumulator is cleared, so that the first sample after the filter is enabled leaves unchanged.
- R7: With `dc_en` high, each valid sample x gives y = x - acc, and then acc becomes acc + floor(coef*(x - acc) / 2^14). Here `dc_coef` is signed with 14 fraction bits (16384 is 1.0), and acc is an 18-bit signed value that is clamped to its own range and starts at 0.
- R8: The filter output saturates to -32768..32767.
- R9: `out_valid` is `in_valid` delayed by exactly two clock cycles. Idle cycles change neither the output data nor the accumulator.
- R10: After a synchronous reset, `out_valid` is 0, `out_data` is 0 and the accumulator is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present on `in_sample` |
| in_sample | input | 14 | Raw converter code |
| fmt_en | input | 1 | Enable format conversion |
| fmt_offbin | input | 1 | 1: code is offset binary, 0: two's complement |
| fmt_sext | input | 1 | Sign-extend in two's complement mode |
| dc_en | input | 1 | Enable the high-pass stage |
| dc_offset | input | 16 | Signed offset added to each sample |
| dc_coef | input | 16 | Signed filter coefficient, 14 fraction bits |
| out_valid | output | 1 | Result present on `out_data` |
| out_data | output | 16 | Signed 16-bit result |

## Verification
The bench checks the code boundaries of every format mode: 0x0000, 0x1FFF, 0x2000 and 0x3FFF. A design that inverted the wrong bit or extended the wrong sign would turn -1 into 16383 or 8191 into -8192. It drives the offset adder and the filter into both saturation limits, where a design without clamping would wrap around to the opposite sign. For the filter it checks unity, half and negative coefficients, re-enabling after the filter was off, and samples separated by idle gaps. A stale accumulator, a shift that rounds toward zero instead of down, or a state that advanced during idle cycles would each push the output sequence away from the model. Every output is timestamped, so a result that arrives one cycle early or late, or a missing or extra valid, is reported.

// File: rtl/adc_cond_pkg.sv
package adc_cond_pkg;

    localparam int RAW_W     = 14;
    localparam int OUT_W     = 16;
    localparam int COEF_W    = 16;
    localparam int COEF_FRAC = 14;
    localparam int ACC_GUARD = 2;
    localparam int ACC_W     = OUT_W + ACC_GUARD;
    localparam int PAD_W     = OUT_W - RAW_W;
    localparam int WIDE_W    = OUT_W + ACC_W + COEF_W;

    typedef logic signed [OUT_W-1:0]  samp_t;
    typedef logic signed [ACC_W-1:0]  acc_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic signed [COEF_W-1:0] coef_t;
    typedef logic [RAW_W-1:0]         raw_t;

    typedef struct packed {
        logic fmt_en;
        logic type_ob;
        logic sext_en;
    } fmt_ctrl_t;

    typedef enum logic [1:0] {
        MODE_RAW    = 2'd0,
        MODE_OFFBIN = 2'd1,
        MODE_TC_EXT = 2'd2,
        MODE_TC_PAD = 2'd3
    } fmt_mode_e;

    typedef struct packed {
        logic  valid;
        samp_t data;
    } beat_t;

    function automatic fmt_mode_e pick_mode(fmt_ctrl_t c);
        if (!c.fmt_en)      return MODE_RAW;
        else if (c.type_ob) return MODE_OFFBIN;
        else if (c.sext_en) return MODE_TC_EXT;
        else                return MODE_TC_PAD;
    endfunction

    function automatic samp_t sat_out(wide_t v);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (OUT_W - 1)) - wide_t'(1);
        lo = -(wide_t'(1) <<< (OUT_W - 1));
        if (v > hi)      return samp_t'(hi);
        else if (v < lo) return samp_t'(lo);
        else             return samp_t'(v);
    endfunction

    function automatic acc_t clamp_acc(wide_t v);
        wide_t hi;
        wide_t lo;
        hi = (wide_t'(1) <<< (ACC_W - 1)) - wide_t'(1);
        lo = -(wide_t'(1) <<< (ACC_W - 1));
        if (v > hi)      return acc_t'(hi);
        else if (v < lo) return acc_t'(lo);
        else             return acc_t'(v);
    endfunction

endpackage

// File: rtl/adc_fmt_stage.sv
module adc_fmt_stage
    import adc_cond_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  raw_t      raw,
    input  fmt_ctrl_t ctrl,
    input  samp_t     offset,
    output beat_t     s1
);

    fmt_mode_e mode;
    raw_t      flipped;
    samp_t     conv;
    samp_t     summed;

    always_comb begin
        mode    = pick_mode(ctrl);
        flipped = {~raw[RAW_W-1], raw[RAW_W-2:0]};
        case (mode)
            MODE_OFFBIN: conv = samp_t'({{PAD_W{flipped[RAW_W-1]}}, flipped});
            MODE_TC_EXT: conv = samp_t'({{PAD_W{raw[RAW_W-1]}}, raw});
            MODE_TC_PAD: conv = samp_t'({{PAD_W{1'b0}}, raw});
            default:     conv = samp_t'({{PAD_W{1'b0}}, raw});
        endcase
        summed = sat_out(wide_t'(conv) + wide_t'(offset));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) s1.data <= summed;
        end
    end

    // R9
    s1_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> s1.valid);

    // R9
    s1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!s1.valid && $stable(s1.data)));

    // R1
    raw_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctrl.fmt_en && offset == '0)
        |=> s1.data == samp_t'({{PAD_W{1'b0}}, $past(raw)}));

endmodule

// File: rtl/adc_dc_hpf.sv
module adc_dc_hpf
    import adc_cond_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  beat_t s1,
    input  logic  dc_en,
    input  coef_t coef,
    output beat_t s2
);

    acc_t  acc;
    wide_t diff;
    wide_t prod;
    wide_t step;
    acc_t  acc_nxt;
    samp_t y;

    always_comb begin
        diff    = wide_t'(s1.data) - wide_t'(acc);
        prod    = wide_t'(coef) * diff;
        step    = prod >>> COEF_FRAC;
        acc_nxt = clamp_acc(wide_t'(acc) + step);
        y       = dc_en ? sat_out(diff) : s1.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2  <= '0;
            acc <= '0;
        end else begin
            s2.valid <= s1.valid;
            if (s1.valid) s2.data <= y;
            if (!dc_en)         acc <= '0;
            else if (s1.valid)  acc <= acc_nxt;
        end
    end

    // R9
    s2_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s1.valid |=> s2.valid);

    // R9
    s2_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !s1.valid |=> (!s2.valid && $stable(s2.data)));

    // R6
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (s1.valid && !dc_en) |=> s2.data == $past(s1.data));

    // R6
    bypass_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !dc_en |=> acc == '0);

    // R9
    acc_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (dc_en && !s1.valid) |=> $stable(acc));

endmodule

// File: rtl/adc_sample_conditioner.sv
module adc_sample_conditioner
    import adc_cond_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [RAW_W-1:0]  in_sample,
    input  logic              fmt_en,
    input  logic              fmt_offbin,
    input  logic              fmt_sext,
    input  logic              dc_en,
    input  logic [OUT_W-1:0]  dc_offset,
    input  logic [COEF_W-1:0] dc_coef,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_data
);

    fmt_ctrl_t ctrl;
    beat_t     s1;
    beat_t     s2;

    always_comb begin
        ctrl.fmt_en  = fmt_en;
        ctrl.type_ob = fmt_offbin;
        ctrl.sext_en = fmt_sext;
    end

    adc_fmt_stage i_fmt (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .raw      (in_sample),
        .ctrl     (ctrl),
        .offset   (samp_t'(dc_offset)),
        .s1       (s1)
    );

    adc_dc_hpf i_hpf (
        .clk   (clk),
        .rst   (rst),
        .s1    (s1),
        .dc_en (dc_en),
        .coef  (coef_t'(dc_coef)),
        .s2    (s2)
    );

    assign out_valid = s2.valid;
    assign out_data  = s2.data;

    // R10
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/test_adc_sample_conditioner.sv
`timescale 1ns/1ps
module test_adc_sample_conditioner;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [13:0] in_sample = '0;
    logic        fmt_en = 1'b0;
    logic        fmt_offbin = 1'b0;
    logic        fmt_sext = 1'b0;
    logic        dc_en = 1'b0;
    logic [15:0] dc_offset = '0;
    logic [15:0] dc_coef = '0;
    logic        out_valid;
    logic [15:0] out_data;

    always #2 clk = ~clk;

    adc_sample_conditioner i_adc_sample_conditioner (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .fmt_en(fmt_en), .fmt_offbin(fmt_offbin), .fmt_sext(fmt_sext),
        .dc_en(dc_en), .dc_offset(dc_offset), .dc_coef(dc_coef),
        .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct {
        int    exp;
        int    due;
        string tag;
    } item_t;

    item_t  sb[$];
    int     checks = 0;
    int     errors = 0;
    int     cyc = 0;
    longint m_acc = 0;
    bit     done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint sat16(longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic longint clamp18(longint v);
        if (v > 131071)  return 131071;
        if (v < -131072) return -131072;
        return v;
    endfunction

    function automatic longint fmt_model(logic [13:0] r);
        longint u;
        u = longint'(r);
        if (!fmt_en) return u;
        if (fmt_offbin) begin
            u = longint'(r ^ 14'h2000);
            return (u >= 8192) ? u - 16384 : u;
        end
        if (fmt_sext) return (u >= 8192) ? u - 16384 : u;
        return u;
    endfunction

    // called at a falling edge; drives one sample and pushes its expectation
    task automatic send(input logic [13:0] raw, input string tag);
        longint x;
        longint y;
        longint c;
        x = sat16(fmt_model(raw) + longint'($signed(dc_offset)));
        if (dc_en) begin
            c = longint'($signed(dc_coef));
            y = sat16(x - m_acc);
            m_acc = clamp18(m_acc + ((c * (x - m_acc)) >>> 14));
        end else begin
            y = x;
            m_acc = 0;
        end
        sb.push_back('{int'(y), cyc + 2, tag});
        in_valid = 1'b1;
        in_sample = raw;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic drain();
        while (sb.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_ctrl(input bit fe, input bit ob, input bit se, input bit de,
                            input int off, input int coef);
        drain();
        fmt_en = fe; fmt_offbin = ob; fmt_sext = se; dc_en = de;
        dc_offset = off[15:0]; dc_coef = coef[15:0];
        if (!de) m_acc = 0;
        @(negedge clk);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R9 unexpected output", int'($signed(out_data)), 0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(int'($signed(out_data)) == it.exp, it.tag, int'($signed(out_data)), it.exp);
                check(cyc == it.due, "R9 latency", cyc, it.due);
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R10 reset state
        check(out_valid == 1'b0, "R10 valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R10 valid after reset", int'(out_valid), 0);
        check(out_data == 16'h0, "R10 data after reset", int'(out_data), 0);

        // R1 no formatting, other bits ignored
        set_ctrl(0, 1, 1, 0, 0, 0);
        send(14'h2ABC, "R1 pad 0x2ABC");
        send(14'h3FFF, "R1 pad 0x3FFF");
        set_ctrl(0, 0, 1, 0, 0, 0);
        send(14'h2000, "R1 pad 0x2000");
        send(14'h0000, "R1 pad 0x0000");

        // R2 offset binary, sext both ways
        set_ctrl(1, 1, 0, 0, 0, 0);
        send(14'h0000, "R2 ob min");
        send(14'h2000, "R2 ob mid");
        send(14'h3FFF, "R2 ob max");
        set_ctrl(1, 1, 1, 0, 0, 0);
        send(14'h0000, "R2 ob min sext");
        send(14'h1FFF, "R2 ob 0x1FFF sext");

        // R3 two's complement, extended
        set_ctrl(1, 0, 1, 0, 0, 0);
        send(14'h3FFF, "R3 tc -1");
        send(14'h2000, "R3 tc min");
        send(14'h1FFF, "R3 tc max");

        // R4 two's complement, padded
        set_ctrl(1, 0, 0, 0, 0, 0);
        send(14'h3FFF, "R4 tc pad 0x3FFF");
        send(14'h2000, "R4 tc pad 0x2000");

        // R5 offset add and saturation
        set_ctrl(1, 0, 1, 0, -100, 0);
        send(14'h0005, "R5 offset -100");
        set_ctrl(0, 0, 0, 0, 32767, 0);
        send(14'h3FFF, "R5 sat high");
        set_ctrl(1, 1, 0, 0, -32768, 0);
        send(14'h0000, "R5 sat low");

        // R7 coefficient zero keeps acc at 0
        set_ctrl(1, 0, 1, 1, 0, 0);
        send(14'h0100, "R7 coef0 a");
        send(14'h3F00, "R7 coef0 b");
        // R7 unity coefficient: difference of successive samples
        set_ctrl(1, 0, 1, 0, 0, 16384);
        set_ctrl(1, 0, 1, 1, 0, 16384);
        send(14'h0064, "R7 unity first");
        send(14'h00C8, "R7 unity second");
        send(14'h3F9C, "R7 unity third");
        // R7 half coefficient on constant input, with idle gaps (R9)
        set_ctrl(1, 0, 1, 0, 1000, 8192);
        set_ctrl(1, 0, 1, 1, 1000, 8192);
        for (int i = 0; i < 6; i++) begin
            send(14'h0000, "R7 half decay");
            repeat (i) @(negedge clk);
        end
        // R7 negative coefficient, floor on negative steps
        set_ctrl(1, 0, 1, 0, 0, -8192);
        set_ctrl(1, 0, 1, 1, 0, -8192);
        send(14'h0007, "R7 neg coef a");
        send(14'h3FF3, "R7 neg coef b");
        send(14'h0003, "R7 neg coef c");

        // R8 filter output saturation
        set_ctrl(1, 0, 1, 0, 32767, 16384);
        set_ctrl(1, 0, 1, 1, 32767, 16384);
        send(14'h1FFF, "R8 charge acc");
        set_ctrl(1, 0, 1, 1, -32768, 16384);
        send(14'h2000, "R8 sat low");
        send(14'h0000, "R8 after sat");

        // R6 disable clears acc, re-enable starts fresh
        set_ctrl(1, 0, 1, 0, 0, 16384);
        send(14'h0123, "R6 bypass");
        set_ctrl(1, 0, 1, 1, 0, 16384);
        send(14'h0200, "R6 first after enable");
        send(14'h0300, "R6 second after enable");

        // R9 back-to-back burst
        for (int i = 0; i < 8; i++) send(14'(i * 37), "R9 burst");
        drain();
        check(sb.size() == 0, "R9 all outputs seen", sb.size(), 0);

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule